// File: doc/BRIEF.md
# Serial EEPROM Bus Slave Engine

This block is the bus-facing half of a 256-byte non-volatile memory that is reached over a two-wire serial bus with an open-drain data line. A fast system clock oversamples the serial clock and data lines. A small counter filter passes a level only after it has held steady for a set number of cycles. The block then finds START and STOP conditions on the cleaned lines, shifts bytes in on the rising edge of the serial clock and out after its falling edge, and answers each byte it accepts by pulling the data line low during the ninth clock.

The block recognises one fixed 7-bit device code. After that code come a read/write flag, an optional word address, and either data bytes to store or data bytes to return. The block does not hold the memory itself. Bytes to be stored leave on a valid/ready write channel. A one-cycle commit pulse tells the memory controller to start its timed programming cycle. Bytes to be returned are fetched on a valid/ready read channel.

While the controller reports busy, the block stays silent on the device address byte. A master can therefore poll for the end of a programming cycle by repeating START and the control byte until it gets an acknowledge.

Channel rules: an offer on either channel is held, with its address and data stable, until the cycle in which ready is high. That cycle is the transfer. A write offer must be taken before the next data byte completes, which is at least nine serial clocks later. A read request must be answered before the serial clock falls at the start of the byte it feeds. `rd_data_i` is sampled in the transfer cycle.

Top module: `eeprom_serial_slave`

## Requirements
- R1: During and right after reset, the data line is released and no write offer, read request or commit pulse is present.
- R2: A pulse shorter than FILT_LEN system clocks on either serial line has no effect on the bytes received or sent.
- R3: SDA falling while SCL is high is a START and restarts the address phase from any state, including the middle of a byte. SDA rising while SCL is high is a STOP and returns the block to idle. In idle, bits are ignored until the next START.
- R4: The first byte after a START is matched as bits 7..1 equal to 1010000, with bit 0 = 1 for read and 0 for write. On a mismatch the block gives no acknowledge and ignores the bus until the next START.
- R5: For each accepted byte, the block drives the data line low during the ninth clock only. It changes its drive only after a falling edge of SCL.
- R6: While `busy_i` is high when the device address byte completes, the block does not acknowledge it.
- R7: In a write, the second byte loads the word pointer. Each later byte is offered on the write channel at the pointer. The pointer then steps in its low PAGE_BITS bits only, wrapping within an 8-byte page (for example 0x1F is followed by 0x18).
- R8: A STOP after at least one data byte in a write, with no START in between, gives exactly one `wr_commit_o` pulse, in the cycle after the STOP is detected. No other event gives one.
- R9: In a read, the byte at the pointer is sent MSB first, starting right after the address acknowledge. Each fetch steps the pointer over the full space (0xFF is followed by 0x00). A master acknowledge (0) continues with the next byte. A master no-acknowledge (1) releases the line until START or STOP.
- R10: A word address written, then a repeated START with the read flag set, returns data starting at that word address.
- R11: Write offers and read requests hold valid, address and data stable until ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin (wired-AND bus value) |
| sda_drive_low_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| busy_i | input | 1 | Controller is in its programming cycle |
| wr_valid_o | output | 1 | Write offer valid |
| wr_ready_i | input | 1 | Controller accepts the write offer |
| wr_addr_o | output | ADDR_W | Byte address of the write offer |
| wr_data_o | output | 8 | Byte value of the write offer |
| wr_commit_o | output | 1 | One-cycle pulse: start the programming cycle |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Controller answers the read request |
| rd_addr_o | output | ADDR_W | Byte address to read |
| rd_data_i | input | 8 | Byte value, sampled in the transfer cycle |

## Verification
The bench builds the block with FILT_LEN = 4, ADDR_W = 8 and PAGE_BITS = 3. A 4-cycle filter lets a two-cycle spike on either line be injected in the middle of a byte and shown to be harmless. An 8-byte page makes the page wrap from 0x1F to 0x18 reachable with a three-byte write. The full 8-bit pointer makes the read wrap from 0xFF to 0x00 reachable with a two-byte read. Ready on both channels is withdrawn on a fixed pattern, so offers are held across stalled cycles. A bench-side busy timer makes acknowledge polling see both a refusal and an acceptance.

// File: rtl/sesl_pkg.sv
package sesl_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_DEV,
    PH_DEV_ACK,
    PH_WADR,
    PH_WADR_ACK,
    PH_WDAT,
    PH_WDAT_ACK,
    PH_RDAT,
    PH_RACK
  } phase_e;

endpackage

// File: rtl/sesl_deglitch.sv
module sesl_deglitch #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_raw,
  output logic level
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  // two-flop synchroniser, then a level that moves only after
  // FILT_LEN consecutive cycles of disagreement
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      level  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], in_raw};
      if (sync_q[1] == level) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        level <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/sesl_line_events.sv
module sesl_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl,
  input  logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_lvl;
      sda_q <= sda_lvl;
    end
  end

  assign scl_rise = scl_lvl & ~scl_q;
  assign scl_fall = ~scl_lvl & scl_q;
  assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/sesl_ptr.sv
module sesl_ptr #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_page,
  input  logic              step_wrap,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] wrap_next, page_next;

  assign wrap_next = ptr + ADDR_W'(1);

  if (PAGE_BITS >= ADDR_W) begin : g_flat
    assign page_next = wrap_next;
  end else begin : g_paged
    assign page_next = {ptr[ADDR_W-1:PAGE_BITS],
                        ptr[PAGE_BITS-1:0] + PAGE_BITS'(1)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr <= '0;
    else if (load)      ptr <= load_val;
    else if (step_page) ptr <= page_next;
    else if (step_wrap) ptr <= wrap_next;
  end
endmodule

// File: rtl/eeprom_serial_slave.sv
module eeprom_serial_slave
  import sesl_pkg::*;
#(
  parameter int         FILT_LEN  = 4,
  parameter int         ADDR_W    = 8,
  parameter int         PAGE_BITS = 3,
  parameter logic [6:0] DEV_CODE  = 7'b1010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_low_o,
  input  logic              busy_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_commit_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i
);
  localparam int NLINES = 2;

  // ---------------- line cleaning ----------------
  logic [NLINES-1:0] raw_lines, filt_lines;
  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    sesl_deglitch #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_raw (raw_lines[g]),
      .level  (filt_lines[g])
    );
  end

  logic scl_f, sda_f;
  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  logic scl_rise, scl_fall, start_ev, stop_ev;
  sesl_line_events u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_f),
    .sda_lvl  (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  // ---------------- sequencer state ----------------
  phase_e            phase_q;
  logic [2:0]        bit_cnt_q;
  logic              byte_done_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic              rw_q, mack_q, drive_q, wrote_q, commit_q;
  logic              wr_valid_q, rd_valid_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [BYTE_W-1:0] wr_data_q;
  logic [ADDR_W-1:0] ptr;

  logic rx_phase, byte_fall, addr_hit, rd_hs;
  logic ptr_load, ptr_step_page;

  assign rx_phase  = (phase_q == PH_DEV) || (phase_q == PH_WADR) ||
                     (phase_q == PH_WDAT);
  assign byte_fall = scl_fall && byte_done_q;
  assign addr_hit  = (rx_q[7:1] == DEV_CODE) && !busy_i;
  assign rd_hs     = rd_valid_q && rd_ready_i;

  assign ptr_load      = (phase_q == PH_WADR) && byte_fall;
  assign ptr_step_page = (phase_q == PH_WDAT) && byte_fall;

  sesl_ptr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ptr_load),
    .load_val  (rx_q[ADDR_W-1:0]),
    .step_page (ptr_step_page),
    .step_wrap (rd_hs),
    .ptr       (ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      bit_cnt_q   <= '0;
      byte_done_q <= 1'b0;
      rx_q        <= '0;
      tx_q        <= '0;
      rw_q        <= 1'b0;
      mack_q      <= 1'b0;
      drive_q     <= 1'b0;
      wrote_q     <= 1'b0;
      commit_q    <= 1'b0;
      wr_valid_q  <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
      rd_valid_q  <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (wr_valid_q && wr_ready_i) wr_valid_q <= 1'b0;
      if (rd_hs) begin
        rd_valid_q <= 1'b0;
        tx_q       <= rd_data_i;
      end

      if (start_ev) begin
        phase_q     <= PH_DEV;
        bit_cnt_q   <= '0;
        byte_done_q <= 1'b0;
        drive_q     <= 1'b0;
        wrote_q     <= 1'b0;
      end else if (stop_ev) begin
        phase_q  <= PH_IDLE;
        drive_q  <= 1'b0;
        commit_q <= wrote_q;
        wrote_q  <= 1'b0;
      end else begin
        if (rx_phase && scl_rise) begin
          rx_q      <= {rx_q[BYTE_W-2:0], sda_f};
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) byte_done_q <= 1'b1;
        end

        case (phase_q)
          PH_DEV: if (byte_fall) begin
            byte_done_q <= 1'b0;
            if (addr_hit) begin
              drive_q <= 1'b1;
              rw_q    <= rx_q[0];
              phase_q <= PH_DEV_ACK;
              if (rx_q[0]) rd_valid_q <= 1'b1;
            end else begin
              phase_q <= PH_IDLE;
            end
          end
          PH_DEV_ACK: if (scl_fall) begin
            bit_cnt_q <= '0;
            if (rw_q) begin
              drive_q <= ~tx_q[7];
              tx_q    <= {tx_q[BYTE_W-2:0], 1'b0};
              phase_q <= PH_RDAT;
            end else begin
              drive_q <= 1'b0;
              phase_q <= PH_WADR;
            end
          end
          PH_WADR: if (byte_fall) begin
            byte_done_q <= 1'b0;
            drive_q     <= 1'b1;
            phase_q     <= PH_WADR_ACK;
          end
          PH_WADR_ACK, PH_WDAT_ACK: if (scl_fall) begin
            drive_q <= 1'b0;
            phase_q <= PH_WDAT;
          end
          PH_WDAT: if (byte_fall) begin
            byte_done_q <= 1'b0;
            drive_q     <= 1'b1;
            wrote_q     <= 1'b1;
            wr_valid_q  <= 1'b1;
            wr_addr_q   <= ptr;
            wr_data_q   <= rx_q;
            phase_q     <= PH_WDAT_ACK;
          end
          PH_RDAT: if (scl_fall) begin
            if (bit_cnt_q == 3'd7) begin
              drive_q <= 1'b0;
              phase_q <= PH_RACK;
            end else begin
              drive_q   <= ~tx_q[7];
              tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
              bit_cnt_q <= bit_cnt_q + 3'd1;
            end
          end
          PH_RACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_f;
              if (!sda_f) rd_valid_q <= 1'b1;
            end
            if (scl_fall) begin
              if (mack_q) begin
                drive_q   <= ~tx_q[7];
                tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
                bit_cnt_q <= '0;
                phase_q   <= PH_RDAT;
              end else begin
                phase_q <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_drive_low_o = drive_q;
  assign wr_valid_o      = wr_valid_q;
  assign wr_addr_o       = wr_addr_q;
  assign wr_data_o       = wr_data_q;
  assign wr_commit_o     = commit_q;
  assign rd_valid_o      = rd_valid_q;
  assign rd_addr_o       = ptr;
endmodule

// File: rtl/sesl_checker.sv
module sesl_checker
  import sesl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input phase_e            phase,
  input logic              scl_fall_ev,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              busy_i,
  input logic              sda_drive_low_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [7:0]        wr_data_o,
  input logic              wr_commit_o,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic [ADDR_W-1:0] rd_addr_o
);
  // R11: a stalled write offer keeps its contents
  a_r11_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

  // R11: a stalled read request keeps its address
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));

  // R6: the address acknowledge is never entered while busy
  a_r6_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DEV_ACK && $past(phase) != PH_DEV_ACK) |-> !$past(busy_i));

  // R8: commit only follows a detected STOP
  a_r8_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> $past(stop_ev));

  // R5: the drive moves only in answer to a clock fall or a bus condition
  a_r5_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sda_drive_low_o) |-> ($past(scl_fall_ev) || $past(start_ev) || $past(stop_ev)));

  // R4: idle never pulls the line
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_IDLE |-> !sda_drive_low_o);
endmodule

bind eeprom_serial_slave sesl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .phase           (phase_q),
  .scl_fall_ev     (scl_fall),
  .start_ev        (start_ev),
  .stop_ev         (stop_ev),
  .busy_i          (busy_i),
  .sda_drive_low_o (sda_drive_low_o),
  .wr_valid_o      (wr_valid_o),
  .wr_ready_i      (wr_ready_i),
  .wr_addr_o       (wr_addr_o),
  .wr_data_o       (wr_data_o),
  .wr_commit_o     (wr_commit_o),
  .rd_valid_o      (rd_valid_o),
  .rd_ready_i      (rd_ready_i),
  .rd_addr_o       (rd_addr_o)
);

// File: tb/eeprom_serial_slave_tb.sv
module eeprom_serial_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FILT_LEN   = 4;
  localparam int ADDR_W     = 8;
  localparam int PAGE_BITS  = 3;
  localparam int Q          = 20;
  localparam int H          = 40;
  localparam int BUSY_CYC   = 3000;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_bus;
  logic sda_drive_low_o;
  logic busy_i;
  logic wr_valid_o, wr_ready_i = 1'b0, wr_commit_o;
  logic [ADDR_W-1:0] wr_addr_o, rd_addr_o;
  logic [7:0] wr_data_o, rd_data_i;
  logic rd_valid_o, rd_ready_i = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus = m_sda & ~sda_drive_low_o;

  eeprom_serial_slave #(
    .FILT_LEN(FILT_LEN), .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_drive_low_o(sda_drive_low_o), .busy_i(busy_i),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_commit_o(wr_commit_o),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i)
  );

  // ---------------- controller model and reference model ----------------
  logic [7:0] ctl_mem [256];
  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr = 8'h00;
  logic [15:0] exp_writes [$];
  logic [7:0] wr_bytes [$];
  int busy_cnt = 0;
  int cyc = 0;
  int vectors = 0;
  int miscompares = 0;
  int seen_commits = 0;
  int exp_commits = 0;

  assign busy_i    = (busy_cnt != 0);
  assign rd_data_i = ctl_mem[rd_addr_o];

  task automatic check1(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string tag);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    wr_ready_i <= (cyc % 3) != 0;
    rd_ready_i <= (cyc % 4) != 1;
    if (rst_n && wr_valid_o && wr_ready_i) begin
      ctl_mem[wr_addr_o] = wr_data_o;
      vectors++;
      if (exp_writes.size() == 0) begin
        miscompares++;
        $display("FAIL R7: actual write %h@%h expected none", wr_data_o, wr_addr_o);
      end else begin
        logic [15:0] e;
        e = exp_writes.pop_front();
        if (e !== {wr_addr_o, wr_data_o}) begin
          miscompares++;
          $display("FAIL R7: actual %h@%h expected %h@%h",
                   wr_data_o, wr_addr_o, e[7:0], e[15:8]);
        end
      end
    end
    if (rst_n && wr_commit_o) begin
      seen_commits++;
      busy_cnt <= BUSY_CYC;
    end else if (busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
    end
  end

  // ---------------- bus tasks ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    m_sda = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; tick(Q);
    scl = 1'b1; tick(H);
    scl = 1'b0; tick(Q);
  endtask

  // spikes of 2 clocks on SCL (while low) and SDA (while SCL high)
  task automatic put_bit_spiky(input logic b);
    m_sda = b;  tick(Q/2);
    scl = 1'b1; tick(2);
    scl = 1'b0; tick(Q/2);
    scl = 1'b1; tick(H/2);
    m_sda = ~b; tick(2);
    m_sda = b;  tick(H/2);
    scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(input logic exp_drv, input string tag);
    m_sda = 1'b1; tick(Q);
    scl = 1'b1;
    repeat (H) begin
      tick(1);
      check1(sda_drive_low_o, exp_drv, tag);
    end
    scl = 1'b0; tick(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(exp_ack, tag);
  endtask

  task automatic read_byte(input logic [7:0] exp, input logic last, input string tag);
    for (int i = 7; i >= 0; i--) get_bit(~exp[i], tag);
    put_bit(last);
  endtask

  task automatic wait_idle();
    while (busy_cnt != 0) tick(1);
    tick(10);
  endtask

  // write sequence using the bytes queued in wr_bytes
  task automatic write_seq(input logic [7:0] addr);
    bus_start();
    write_byte(8'hA0, 1'b1, "R4");
    write_byte(addr, 1'b1, "R5");
    ref_ptr = addr;
    while (wr_bytes.size() > 0) begin
      logic [7:0] d;
      d = wr_bytes.pop_front();
      exp_writes.push_back({ref_ptr, d});
      ref_mem[ref_ptr] = d;
      write_byte(d, 1'b1, "R7");
      ref_ptr = {ref_ptr[7:3], ref_ptr[2:0] + 3'd1};
    end
    bus_stop();
    exp_commits++;
  endtask

  task automatic read_run(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      read_byte(ref_mem[ref_ptr], (k == n - 1), tag);
      ref_ptr = ref_ptr + 8'd1;
    end
  endtask

  task automatic rand_read(input logic [7:0] addr, input int n, input logic spiky,
                           input string tag);
    bus_start();
    write_byte(8'hA0, 1'b1, "R4");
    if (spiky) begin
      for (int i = 7; i >= 0; i--) put_bit_spiky(addr[i]);
      get_bit(1'b1, "R2");
    end else begin
      write_byte(addr, 1'b1, "R10");
    end
    ref_ptr = addr;
    bus_start();
    write_byte(8'hA1, 1'b1, "R10");
    read_run(n, tag);
    bus_stop();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ctl_mem[i] = 8'(i) ^ 8'h3C;
      ref_mem[i] = 8'(i) ^ 8'h3C;
    end
    tick(3);
    // R1: reset state
    check1(sda_drive_low_o, 1'b0, "R1");
    check1(wr_valid_o, 1'b0, "R1");
    rst_n = 1'b1;
    tick(5);
    check1(sda_drive_low_o, 1'b0, "R1");
    check1(rd_valid_o, 1'b0, "R1");
    check1(wr_commit_o, 1'b0, "R1");

    // R4: wrong device codes are not acknowledged, rest of transfer ignored
    bus_start();
    write_byte(8'hA2, 1'b0, "R4");
    write_byte(8'h10, 1'b0, "R4");
    bus_stop();
    bus_start();
    write_byte(8'h20, 1'b0, "R4");
    bus_stop();

    // R7/R8: single byte write
    wr_bytes.push_back(8'h5A);
    write_seq(8'h10);
    tick(2);
    check_int(seen_commits, exp_commits, "R8");

    // R6: polling while busy gets no acknowledge
    bus_start();
    write_byte(8'hA0, 1'b0, "R6");
    bus_stop();
    wait_idle();
    bus_start();
    write_byte(8'hA0, 1'b1, "R6");
    bus_stop();
    tick(4);
    check_int(seen_commits, exp_commits, "R8");

    // R10: random read of the written byte
    rand_read(8'h10, 1, 1'b0, "R10");
    // R9: current address read continues from the pointer
    bus_start();
    write_byte(8'hA1, 1'b1, "R9");
    read_run(1, "R9");
    bus_stop();

    // R7: page write wrapping 0x1F -> 0x18
    wr_bytes.push_back(8'h11);
    wr_bytes.push_back(8'h22);
    wr_bytes.push_back(8'h33);
    write_seq(8'h1E);
    wait_idle();
    check_int(seen_commits, exp_commits, "R8");
    check_int(exp_writes.size(), 0, "R11");

    // R9: sequential read over the page, then current read
    rand_read(8'h18, 8, 1'b0, "R9");
    bus_start();
    write_byte(8'hA1, 1'b1, "R9");
    read_run(1, "R9");
    bus_stop();

    // R9: read wraps 0xFF -> 0x00
    rand_read(8'hFF, 2, 1'b0, "R9");

    // R3: START in the middle of a byte restarts the address phase
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    write_byte(8'hA1, 1'b1, "R3");
    read_run(1, "R3");
    bus_stop();

    // R3: bits after STOP without a START are ignored
    write_byte(8'hA0, 1'b0, "R3");
    bus_stop();

    // R2: spikes on both lines inside the word address
    rand_read(8'h1E, 2, 1'b1, "R2");

    tick(20);
    check_int(seen_commits, exp_commits, "R8");
    check_int(exp_writes.size(), 0, "R7");
    finish_run();
  end
endmodule